// File: doc/BRIEF.md
# External Bus Request/Grant Arbiter

This block decides when the processor lets an external master take its external memory bus. An external master raises a bus request. The arbiter brings that request into the local clock domain and waits until the core has no external access on the bus. It then floats the address, data and strobe drivers, asserts bus grant and halts the core. The grant can arrive between the two external accesses of a single instruction, because the arbiter only waits for the access in flight and never for the whole instruction.

When go mode is enabled, the grant does not stop the core at once. The core keeps running until it wants an external access. From then on it is halted, and a hang flag reports that it is waiting for the bus. When the request is withdrawn, the arbiter drops grant, turns the drivers back on and lets the core continue. The pending access then proceeds. A guard interval of idle cycles always separates the return of the bus from any new grant. The arbiter has its own reset and keeps arbitrating while the core is held in reset or is booting.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While rst_n is low and right after it is released, bus_grant, bus_hiz, core_halt and bus_hang are all 0.
- R2: bus_req passes through SYNC_STAGES flops (default 2). With ext_busy low and go_en low, bus_grant, bus_hiz and core_halt rise together SYNC_STAGES+1 clock edges after bus_req is first sampled high (3 edges by default).
- R3: A new grant is never given at an edge where ext_busy is sampled high. The grant is given at the first edge where ext_busy is sampled low and the synchronized request is high.
- R4: A single idle cycle of ext_busy between two back-to-back external accesses is enough for the grant to be given in that gap.
- R5: With go_en high, core_halt stays 0 during a grant while ext_need is 0, and becomes 1 in the same cycle that ext_need is 1.
- R6: bus_hang is 1 exactly when the bus is granted and ext_need is 1. It is 0 when no grant is held, even if ext_need is 1.
- R7: SYNC_STAGES+1 edges after bus_req is sampled low, bus_grant, bus_hiz, core_halt and bus_hang all return to 0.
- R8: After bus_grant falls, it stays 0 for at least GAP_CYCLES cycles (default 1) even if the request is already high again. The grant then returns on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset of the arbiter only |
| bus_req | input | 1 | Bus request from the external master, asynchronous |
| ext_busy | input | 1 | An external access by the core is on the bus this cycle |
| ext_need | input | 1 | The core is ready to issue an external access |
| go_en | input | 1 | Go mode: the core keeps running during a grant until it needs the bus |
| bus_grant | output | 1 | Bus granted to the external master |
| bus_hiz | output | 1 | Float the address, data and strobe drivers |
| core_halt | output | 1 | Stall the core |
| bus_hang | output | 1 | The core is stalled waiting for a granted-away bus |

## Verification
The hardest case to reach is a grant that lands in the one-cycle gap between two external accesses of the same instruction. To reach it, the stimulus keeps ext_busy high until the synchronized request is certainly present. It then opens a single low cycle and raises ext_busy again. The grant must appear on exactly that edge, and on no edge where ext_busy is high. A second difficult case is the guard interval. The request is dropped for a single cycle, so that the re-raised request reaches the arbiter on the edge just after grant falls, and that edge must refuse the grant.

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic ext_busy,
  input  logic ext_need,
  input  logic go_en,
  output logic bus_grant,
  output logic bus_hiz,
  output logic core_halt,
  output logic bus_hang
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_s;
  logic                   grant_q;
  logic [GW-1:0]          gap_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], bus_req};

  assign req_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grant_q <= 1'b0;
      gap_cnt <= '0;
    end else if (grant_q) begin
      if (!req_s) begin
        grant_q <= 1'b0;
        gap_cnt <= GW'(GAP_CYCLES);
      end
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end else if (req_s && !ext_busy) begin
      grant_q <= 1'b1;
    end

  assign bus_grant = grant_q;
  assign bus_hiz   = grant_q;
  assign bus_hang  = grant_q && ext_need;
  assign core_halt = grant_q && (!go_en || ext_need);

  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && ext_busy) |=> !bus_grant);

  a_r2_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> ($past(req_s) && !$past(ext_busy)));

  a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |-> !$past(req_s));

  a_r8_guard_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |=> !bus_grant);

  a_r6_hang_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hang |-> (core_halt && bus_hiz));
endmodule

// File: tb/tb_bus_grant_arbiter.sv
module tb_bus_grant_arbiter;
  localparam int PERIOD = 10;

  typedef struct {
    int    cyc;
    logic  g, z, h, hg;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, bus_req = 0, ext_busy = 0, ext_need = 0, go_en = 0;
  logic bus_grant, bus_hiz, core_halt, bus_hang;
  int   cyc = 0, n_chk = 0, n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  bus_grant_arbiter dut (.clk, .rst_n, .bus_req, .ext_busy, .ext_need, .go_en,
                         .bus_grant, .bus_hiz, .core_halt, .bus_hang);

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int ofs, logic g, logic z, logic h, logic hg, string tag);
    exp_t e;
    e.cyc = cyc + ofs; e.g = g; e.z = z; e.h = h; e.hg = hg; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #(PERIOD/4);
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.cyc != cyc || {bus_grant, bus_hiz, core_halt, bus_hang} != {e.g, e.z, e.h, e.hg}) begin
        n_fail++;
        $display("FAIL %s cyc %0d: grant/hiz/halt/hang actual %b%b%b%b expected %b%b%b%b",
                 e.tag, cyc, bus_grant, bus_hiz, core_halt, bus_hang, e.g, e.z, e.h, e.hg);
      end
    end
  end

  initial begin
    @(negedge clk);
    expect_at(0, 0, 0, 0, 0, "R1 in reset");
    wait_cyc(3);
    rst_n = 1;
    expect_at(1, 0, 0, 0, 0, "R1 after reset");
    wait_cyc(3);

    // R2 plain grant
    bus_req = 1;
    expect_at(2, 0, 0, 0, 0, "R2 before sync");
    expect_at(3, 1, 1, 1, 0, "R2 grant");
    wait_cyc(4);
    // R6 hang while granted
    ext_need = 1;
    expect_at(0, 1, 1, 1, 1, "R6 hang set");
    wait_cyc(1);
    // R7 release with pending access
    bus_req = 0;
    expect_at(2, 1, 1, 1, 1, "R7 still held");
    expect_at(3, 0, 0, 0, 0, "R7 released, R6 hang clear");
    wait_cyc(6);
    ext_need = 0;

    // R8 guard gap: one-cycle request dip
    bus_req = 1;
    wait_cyc(5);
    bus_req = 0;
    wait_cyc(1);
    bus_req = 1;
    expect_at(2, 0, 0, 0, 0, "R8 grant dropped");
    expect_at(3, 0, 0, 0, 0, "R8 guard cycle");
    expect_at(4, 1, 1, 1, 0, "R8 regrant");
    wait_cyc(6);
    bus_req = 0;
    wait_cyc(6);

    // R3 busy blocks grant
    ext_busy = 1; bus_req = 1;
    expect_at(3, 0, 0, 0, 0, "R3 blocked");
    expect_at(5, 0, 0, 0, 0, "R3 still blocked");
    wait_cyc(5);
    ext_busy = 0;
    expect_at(1, 1, 1, 1, 0, "R3 grant after access");
    wait_cyc(3);
    bus_req = 0;
    wait_cyc(6);

    // R4 grant between two accesses
    ext_busy = 1; bus_req = 1;
    wait_cyc(4);
    ext_busy = 0;
    expect_at(1, 1, 1, 1, 0, "R4 grant in gap");
    wait_cyc(1);
    ext_busy = 1;
    expect_at(1, 1, 1, 1, 0, "R4 grant kept");
    wait_cyc(1);
    ext_busy = 0;
    bus_req = 0;
    wait_cyc(6);

    // R5 go mode
    go_en = 1; bus_req = 1;
    expect_at(3, 1, 1, 0, 0, "R5 grant, core runs");
    wait_cyc(4);
    ext_need = 1;
    expect_at(0, 1, 1, 1, 1, "R5 halt on need");
    wait_cyc(1);
    bus_req = 0;
    expect_at(3, 0, 0, 0, 0, "R7 go-mode release");
    wait_cyc(5);
    ext_need = 0;
    wait_cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule